// File: doc/BRIEF.md
# Fractional Resampler Timing Controller

This block schedules the events of a fractional sample-rate converter that runs from one fixed master clock with no relation between the input and output rates. It keeps two wide time stamps, for the next input sample and for the next output sample. Every clock cycle it issues exactly one event. A shift event tells the register bank to take in the next input sample. A compute event tells the filter datapath to produce an output sample.

For each compute event the block also gives the polyphase branch and the linear-interpolation weight. Both come from the distance between the output time and the most recently shifted input. Time is counted in units of the coefficient grid spacing and held as 70-bit unsigned fixed point with `FRAC_W` fractional bits. This is wide enough to set both periods to a 1 Hz resolution anywhere between 3 MHz and 61.44 MHz. Rounding error must not build up over time, so the timeline is restarted after a programmable number of samples, at a point where the output time is expected to fall exactly on an input period.

Top module: `frac_interp_ctrl`

## Requirements
- R1: While reset is asserted, and for the two cycles the reset synchroniser needs after release, `shift_o` and `compute_o` are 0 and `phase_o` and `weight_o` are zero.
- R2: From the third rising edge after reset release, exactly one of `shift_o` and `compute_o` is 1 in every cycle.
- R3: Both time stamps start at 0. A shift is issued when the next-input time is less than or equal to the next-output time; otherwise a compute is issued. On a tie, the shift comes first. A shift advances the next-input time by `in_step_i`. A compute advances the next-output time by `out_step_i`.
- R4: On a compute, `phase_o` equals the integer part of (output time minus the time of the last shifted input) modulo `PHASES`. This is bits [FRAC_W +: log2(PHASES)] of the difference.
- R5: On a compute, `weight_o` is the top 16 fractional bits of that same difference, bits [FRAC_W-1 -: 16].
- R6: In any cycle where `compute_o` is 0, `phase_o` and `weight_o` are zero.
- R7: When `out_step_i` < `in_step_i` (upsampling), more computes than shifts are issued. When `out_step_i` > `in_step_i` (downsampling), fewer computes than shifts are issued.
- R8: When the counted event reaches `RESYNC_N`, all time stamps return to 0 after that event. The next event is then a shift, and the compute after it has phase 0 and weight 0.
- R9: `mode_up_i` = 1 counts compute events toward `RESYNC_N`. `mode_up_i` = 0 counts shift events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| mode_up_i | input | 1 | 1 = upsampling (count outputs), 0 = downsampling (count inputs) |
| in_step_i | input | TIME_W | input period in grid units, FRAC_W fractional bits, non-zero |
| out_step_i | input | TIME_W | output period in grid units, FRAC_W fractional bits, non-zero |
| shift_o | output | 1 | shift the next input sample into the register bank |
| compute_o | output | 1 | compute one output sample |
| phase_o | output | log2(PHASES) | polyphase branch for this output |
| weight_o | output | WEIGHT_W | interpolation weight for this output |

## Verification
The bench builds the block with the default 70-bit time, 40 fractional bits, 8 phases and a 16-bit weight. It lowers `RESYNC_N` to 6, so that several timeline restarts happen within each short scenario in both modes. The scenarios use an integer-to-fractional upsampling ratio, a fractional downsampling ratio, equal periods that force a tie on every input, and a step with dense low fraction bits. Together they exercise the branch wrap-around, the weight bits and the shift-first ordering on a tie.

// File: rtl/fic_pkg.sv
package fic_pkg;
  typedef enum logic {
    EV_SHIFT   = 1'b0,
    EV_COMPUTE = 1'b1
  } fic_event_e;
endpackage

// File: rtl/fic_rst_sync.sv
module fic_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/fic_event_sched.sv
module fic_event_sched
  import fic_pkg::*;
#(
  parameter int TIME_W = 70
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] in_step_i,
  input  logic [TIME_W-1:0] out_step_i,
  input  logic              restart_i,
  output fic_event_e        ev_o,
  output logic [TIME_W-1:0] t_out_o,
  output logic [TIME_W-1:0] t_ref_o
);
  logic [TIME_W-1:0] t_in_q, t_out_q, t_ref_q;
  logic [TIME_W-1:0] t_in_d, t_out_d, t_ref_d;
  logic              in_en, out_en, ref_en;
  fic_event_e        ev;

  // one event per cycle; tie goes to the input side
  assign ev = (t_in_q <= t_out_q) ? EV_SHIFT : EV_COMPUTE;

  always_comb begin
    in_en   = (ev == EV_SHIFT) || restart_i;
    ref_en  = in_en;
    out_en  = (ev == EV_COMPUTE) || restart_i;
    t_in_d  = t_in_q + in_step_i;
    t_ref_d = t_in_q;
    t_out_d = t_out_q + out_step_i;
    if (restart_i) begin
      t_in_d  = '0;
      t_ref_d = '0;
      t_out_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_in_q  <= '0;
      t_out_q <= '0;
      t_ref_q <= '0;
    end else begin
      if (in_en)  t_in_q  <= t_in_d;
      if (out_en) t_out_q <= t_out_d;
      if (ref_en) t_ref_q <= t_ref_d;
    end
  end

  assign ev_o    = ev;
  assign t_out_o = t_out_q;
  assign t_ref_o = t_ref_q;
endmodule

// File: rtl/fic_resync_cnt.sv
module fic_resync_cnt
  import fic_pkg::*;
#(
  parameter int RESYNC_N = 1000,
  localparam int CNT_W   = $clog2(RESYNC_N + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_up_i,
  input  fic_event_e ev_i,
  output logic       restart_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             counted, cnt_en;

  assign counted   = mode_up_i ? (ev_i == EV_COMPUTE) : (ev_i == EV_SHIFT);
  assign restart_o = counted && (cnt_q == CNT_W'(RESYNC_N - 1));

  always_comb begin
    cnt_en = counted;
    cnt_d  = restart_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fic_phase_weight.sv
module fic_phase_weight
  import fic_pkg::*;
#(
  parameter int TIME_W   = 70,
  parameter int FRAC_W   = 40,
  parameter int PH_W     = 3,
  parameter int WEIGHT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fic_event_e          ev_i,
  input  logic [TIME_W-1:0]   t_out_i,
  input  logic [TIME_W-1:0]   t_ref_i,
  output logic                shift_o,
  output logic                compute_o,
  output logic [PH_W-1:0]     phase_o,
  output logic [WEIGHT_W-1:0] weight_o
);
  logic [TIME_W-1:0]   offset;
  logic [PH_W-1:0]     phase_d;
  logic [WEIGHT_W-1:0] weight_d;

  always_comb begin
    offset   = t_out_i - t_ref_i;
    phase_d  = '0;
    weight_d = '0;
    if (ev_i == EV_COMPUTE) begin
      phase_d  = offset[FRAC_W +: PH_W];
      weight_d = offset[FRAC_W-1 -: WEIGHT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_o   <= 1'b0;
      compute_o <= 1'b0;
      phase_o   <= '0;
      weight_o  <= '0;
    end else begin
      shift_o   <= (ev_i == EV_SHIFT);
      compute_o <= (ev_i == EV_COMPUTE);
      phase_o   <= phase_d;
      weight_o  <= weight_d;
    end
  end
endmodule

// File: rtl/frac_interp_ctrl.sv
module frac_interp_ctrl
  import fic_pkg::*;
#(
  parameter int TIME_W   = 70,
  parameter int FRAC_W   = 40,
  parameter int PHASES   = 8,
  parameter int WEIGHT_W = 16,
  parameter int RESYNC_N = 1000,
  localparam int PH_W    = $clog2(PHASES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_up_i,
  input  logic [TIME_W-1:0]   in_step_i,
  input  logic [TIME_W-1:0]   out_step_i,
  output logic                shift_o,
  output logic                compute_o,
  output logic [PH_W-1:0]     phase_o,
  output logic [WEIGHT_W-1:0] weight_o
);
  logic              rst_sync_n;
  logic              restart;
  fic_event_e        ev;
  logic [TIME_W-1:0] t_out, t_ref;

  fic_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  fic_event_sched #(.TIME_W(TIME_W)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .in_step_i  (in_step_i),
    .out_step_i (out_step_i),
    .restart_i  (restart),
    .ev_o       (ev),
    .t_out_o    (t_out),
    .t_ref_o    (t_ref)
  );

  fic_resync_cnt #(.RESYNC_N(RESYNC_N)) u_resync (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .mode_up_i (mode_up_i),
    .ev_i      (ev),
    .restart_o (restart)
  );

  fic_phase_weight #(
    .TIME_W(TIME_W), .FRAC_W(FRAC_W), .PH_W(PH_W), .WEIGHT_W(WEIGHT_W)
  ) u_pw (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .ev_i      (ev),
    .t_out_i   (t_out),
    .t_ref_i   (t_ref),
    .shift_o   (shift_o),
    .compute_o (compute_o),
    .phase_o   (phase_o),
    .weight_o  (weight_o)
  );
endmodule

// File: rtl/frac_interp_ctrl_chk.sv
module frac_interp_ctrl_chk #(
  parameter int PH_W     = 3,
  parameter int WEIGHT_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                shift_o,
  input logic                compute_o,
  input logic [PH_W-1:0]     phase_o,
  input logic [WEIGHT_W-1:0] weight_o
);
  logic [1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= 2'd0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!shift_o && !compute_o && phase_o == '0 && weight_o == '0);
    end
  end

  assert_single_event_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({shift_o, compute_o}));

  assert_event_every_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) |-> $onehot({shift_o, compute_o}));

  assert_idle_outputs_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !compute_o |-> (phase_o == '0 && weight_o == '0));
endmodule

bind frac_interp_ctrl frac_interp_ctrl_chk #(.PH_W(PH_W), .WEIGHT_W(WEIGHT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shift_o   (shift_o),
  .compute_o (compute_o),
  .phase_o   (phase_o),
  .weight_o  (weight_o)
);

// File: tb/frac_interp_ctrl_tb.sv
module frac_interp_ctrl_tb;
  localparam int TW = 70;
  localparam int FW = 40;
  localparam int RS = 6;

  logic          clk, rst_n, mode_up;
  logic [TW-1:0] in_step, out_step;
  logic          shift, comp;
  logic [2:0]    phase;
  logic [15:0]   weight;
  int            checks, failures;

  frac_interp_ctrl #(.RESYNC_N(RS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_up_i(mode_up),
    .in_step_i(in_step), .out_step_i(out_step),
    .shift_o(shift), .compute_o(comp), .phase_o(phase), .weight_o(weight)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input bit up, input logic [TW-1:0] is, input logic [TW-1:0] os,
                          input int ncyc, input string name);
    logic [TW-1:0] m_in, m_out, m_ref, off;
    int            m_cnt, n_sh, n_cp, after_rs;
    bit            e_sh, counted;
    logic [2:0]    e_ph;
    logic [15:0]   e_w;
    $display("scenario %s", name);
    rst_n = 1'b0; mode_up = up; in_step = is; out_step = os;
    repeat (2) @(negedge clk);
    check(!shift && !comp && phase == 0 && weight == 0, "R1 reset", {shift, comp}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); @(negedge clk);
      check(!shift && !comp && weight == 0, "R1 sync window", {shift, comp}, 0);
    end
    m_in = '0; m_out = '0; m_ref = '0; m_cnt = 0; n_sh = 0; n_cp = 0; after_rs = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); @(negedge clk);
      e_sh = (m_in <= m_out);
      e_ph = '0; e_w = '0;
      if (e_sh) begin
        m_ref = m_in; m_in = m_in + is; counted = !up; n_sh++;
      end else begin
        off = m_out - m_ref; e_ph = off[FW +: 3]; e_w = off[FW-1 -: 16];
        m_out = m_out + os; counted = up; n_cp++;
      end
      check(shift + comp == 1, "R2 one event", {shift, comp}, {1'b0, 1'b1});
      check(shift == e_sh && comp == !e_sh, "R3 event order", {shift, comp}, {e_sh, !e_sh});
      if (!e_sh) begin
        check(phase == e_ph, "R4 phase", phase, e_ph);
        check(weight == e_w, "R5 weight", weight, e_w);
      end else begin
        check(phase == 0 && weight == 0, "R6 zero on shift", {phase, weight}, 0);
      end
      if (after_rs == 2) begin
        check(shift, up ? "R8 restart shift" : "R9 restart after shifts", shift, 1);
        after_rs = 1;
      end else if (after_rs == 1 && comp) begin
        check(phase == 0 && weight == 0, "R8 restart offset", {phase, weight}, 0);
        after_rs = 0;
      end
      if (counted) begin
        if (m_cnt == RS - 1) begin
          m_cnt = 0; m_in = '0; m_out = '0; m_ref = '0; after_rs = 2;
        end else m_cnt++;
      end
    end
    if (os < is) check(n_cp > n_sh, "R7 upsampling rate", n_cp, n_sh);
    if (os > is) check(n_cp < n_sh, "R7 downsampling rate", n_cp, n_sh);
  endtask

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; mode_up = 1'b1; in_step = '0; out_step = '0;
    run_case(1'b1, TW'(8) << FW, TW'(11) << (FW - 1), 60, "up 8.0/5.5");
    run_case(1'b0, TW'(9) << (FW - 2), TW'(8) << FW, 60, "down 2.25/8.0");
    run_case(1'b1, TW'(4) << FW, TW'(4) << FW, 30, "tie 4.0/4.0");
    run_case(1'b1, TW'(7) << FW, (TW'(3) << FW) | TW'(40'h12_3456_789A), 60, "up fine fraction");
    run_case(1'b0, TW'(3) << FW, (TW'(10) << FW) | TW'(40'h80_0000_0001), 60, "down fine fraction");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule